// File: doc/BRIEF.md
# MII Receive Timestamp Inserter

This block sits in the receive nibble stream between a PHY and a MAC. It watches each frame for a clock-synchronization type code and, when it sees one, overwrites a reserved 8-byte slot in the payload with the local time. The local time is captured when the start delimiter arrives. All other frames leave the block exactly as they came in.

Two nibble-wide CRC-32 engines run side by side. The input engine runs over the received frame, including its FCS, and checks the residue. The output engine runs over the frame as it leaves, after modification. For a synchronization frame, the output FCS is replaced with the recomputed checksum. If the incoming check failed, the replacement is the bitwise inverse of that checksum, so the MAC still rejects the frame.

The stream is valid-only (`in_dv`/`out_dv`) with no back-pressure. The PHY cannot be stalled, so the block accepts one nibble on every cycle in which `in_dv` is high. It delivers one nibble per cycle on the output, after a fixed latency, and never holds data back. Transmit-side timestamping is a separate instance of similar logic and is outside this block.

Top module: `rxts_inserter`

## Requirements
- R1: `out_dv` repeats `in_dv` exactly 9 clock cycles later. While `out_dv` is low, `out_nib` is 0. After reset, both outputs are 0.
- R2: A frame whose type code is not `CSP_TYPE` is reproduced nibble for nibble, including its original FCS. This holds whether that FCS is right or wrong.
- R3: Framing rules:
  - Before the delimiter, every input nibble is preamble and is passed through unchanged. The first nibble 0xD seen while `in_dv` is high is the delimiter, however many preamble nibbles came before it.
  - The next nibble is the low nibble of frame byte 0. Each byte arrives low nibble first.
  - The type code is byte 12 (high half) followed by byte 13 (low half). A byte-swapped code does not match.
- R4: In a synchronization frame, frame bytes 22 to 29 (payload bytes 8 to 15) are replaced by the 64-bit timestamp, most significant byte first. Every other byte before the FCS is unchanged, including the transmit-time slot at payload bytes 0 to 7.
- R5: The inserted timestamp is the value on `ts_in` in the cycle the delimiter nibble is accepted. Later changes on `ts_in` during the frame have no effect.
- R6: When the received FCS of a synchronization frame is correct, the output FCS replaces it. The output FCS is the standard Ethernet CRC-32 over bytes 0 onward of the modified frame: reflected polynomial 0xEDB88320, initial value all ones, final inversion, sent least significant nibble first.
- R7: When the received FCS of a synchronization frame is wrong, the output FCS is the bitwise inverse of the value R6 would give.
- R8: Frames separated by a single idle cycle are each processed independently, with their own timestamp and their own FCS decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ts_in | input | 64 | Free-running local time from the time source |
| in_dv | input | 1 | Input nibble valid; high for the whole frame |
| in_nib | input | 4 | Input nibble from the PHY |
| out_dv | output | 1 | Output nibble valid, delayed by 9 cycles |
| out_nib | output | 4 | Output nibble towards the MAC |

## Verification
The assertions assume that `in_dv` stays high without gaps for each whole frame. They also assume every frame is at least 64 bytes after the delimiter, so that the FCS never reaches back into the timestamp slot or the preamble.

Input nibbles are compared only while valid; outside a frame, `out_nib` is checked against zero. The directed stimulus keeps inside these limits: preambles end in a delimiter, bodies carry 64 bytes, frames are separated by at least one idle cycle, and `in_nib` is held at zero between frames.

// File: rtl/rxts_pkg.sv
package rxts_pkg;
  localparam int          CRC_W       = 32;
  localparam int          NIB_W       = 4;
  localparam logic [31:0] CRC_POLY_RF = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED    = 32'hFFFFFFFF;
  // Remainder of a reflected, non-inverted CRC run over data plus a good FCS.
  localparam logic [31:0] CRC_GOOD_RES = 32'hDEBB20E3;
  localparam logic [3:0]  DELIM_NIB    = 4'hD;

  typedef enum logic { PS_HUNT, PS_BODY } parse_st_e;

  typedef struct packed {
    logic            dv;
    logic            body;
    logic            ins;
    logic [NIB_W-1:0] nib;
  } stage_t;

  function automatic logic [CRC_W-1:0] crc_nib_step(input logic [CRC_W-1:0] c,
                                                    input logic [NIB_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < NIB_W; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_RF;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxts_crc_nib.sv
module rxts_crc_nib
  import rxts_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [NIB_W-1:0] nib,
  output logic [CRC_W-1:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= CRC_SEED;
    else if (clr) crc <= CRC_SEED;
    else if (en)  crc <= crc_nib_step(crc, nib);
  end
endmodule

// File: rtl/rxts_frame_parse.sv
module rxts_frame_parse
  import rxts_pkg::*;
#(
  parameter logic [15:0] CSP_TYPE     = 16'h88B5,
  parameter int          TS_W         = 64,
  parameter int          HDR_BYTES    = 14,
  parameter int          TS_SLOT_BYTE = 8,
  parameter int          IDX_W        = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_dv,
  input  logic [NIB_W-1:0] in_nib,
  input  logic [TS_W-1:0]  ts_in,
  output stage_t           st_out,
  output logic             csp_hit,
  output logic             fcs_ok,
  output logic             ins_en
);
  localparam int TYPE_NIB = 2 * (HDR_BYTES - 2);
  localparam int TS_NIB0  = 2 * (HDR_BYTES + TS_SLOT_BYTE);
  localparam int TS_NIBS  = TS_W / NIB_W;
  localparam int KW       = $clog2(TS_NIBS);
  localparam logic [IDX_W-1:0] IDX_LIM = '1;

  parse_st_e        st_q;
  logic [IDX_W-1:0] idx_q;
  logic [11:0]      type_sr_q;
  logic [TS_W-1:0]  ts_q;
  logic             sfd_hit;
  logic             body;
  logic [15:0]      type_word;
  logic [IDX_W-1:0] k_full;
  logic [KW-1:0]    k;
  int               pos;
  logic [TS_W-1:0]  ts_sh;
  logic [CRC_W-1:0] chk_crc;

  assign sfd_hit = in_dv && (st_q == PS_HUNT) && (in_nib == DELIM_NIB);
  assign body    = in_dv && (st_q == PS_BODY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st_q <= PS_HUNT;
    else if (!in_dv)  st_q <= PS_HUNT;
    else if (sfd_hit) st_q <= PS_BODY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        idx_q <= '0;
    else if (sfd_hit)                  idx_q <= '0;
    else if (body && idx_q != IDX_LIM) idx_q <= idx_q + 1'b1;
  end

  // Type nibbles arrive n24 (byte12 low), n25, n26, n27 (byte13 high).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) type_sr_q <= '0;
    else if (body && idx_q >= IDX_W'(TYPE_NIB) && idx_q < IDX_W'(TYPE_NIB + 3))
      type_sr_q <= {in_nib, type_sr_q[11:4]};
  end

  assign type_word = {type_sr_q[7:4], type_sr_q[3:0], in_nib, type_sr_q[11:8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       csp_hit <= 1'b0;
    else if (sfd_hit) csp_hit <= 1'b0;
    else if (body && idx_q == IDX_W'(TYPE_NIB + 3))
      csp_hit <= (type_word == CSP_TYPE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ts_q <= '0;
    else if (sfd_hit) ts_q <= ts_in;
  end

  assign ins_en = body && csp_hit &&
                  idx_q >= IDX_W'(TS_NIB0) && idx_q < IDX_W'(TS_NIB0 + TS_NIBS);
  assign k_full = idx_q - IDX_W'(TS_NIB0);
  assign k      = k_full[KW-1:0];

  // Byte k/2 counted from the most significant end, low nibble at even k.
  always_comb begin
    pos   = (TS_W - 8) - 8 * int'(k[KW-1:1]) + 4 * int'(k[0]);
    ts_sh = ts_q >> pos;
  end

  always_comb begin
    st_out.dv   = in_dv;
    st_out.body = body;
    st_out.ins  = ins_en;
    if (!in_dv)      st_out.nib = '0;
    else if (ins_en) st_out.nib = ts_sh[NIB_W-1:0];
    else             st_out.nib = in_nib;
  end

  rxts_crc_nib u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (sfd_hit),
    .en   (body),
    .nib  (in_nib),
    .crc  (chk_crc)
  );

  assign fcs_ok = (chk_crc == CRC_GOOD_RES);
endmodule

// File: rtl/rxts_fcs_out.sv
module rxts_fcs_out
  import rxts_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stage_t           st_in,
  input  logic             csp_hit,
  input  logic             fcs_ok,
  output logic             out_dv,
  output logic [NIB_W-1:0] out_nib,
  output logic             out_mod,
  output logic             fcs_active
);
  localparam int CNT_W = $clog2(DEPTH);

  stage_t [DEPTH-1:0] pipe;
  stage_t             head;
  logic               end_now;
  logic               in_tail;
  logic [CNT_W-1:0]   tail_q;
  logic               rep_q;
  logic [CRC_W-1:0]   shift_q;
  logic [CRC_W-1:0]   gen_crc;
  logic [CRC_W-1:0]   word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[DEPTH-2:0], st_in};
  end

  assign head    = pipe[DEPTH-1];
  // Input valid just dropped: the pipe now holds exactly the received FCS.
  assign end_now = pipe[0].body && !st_in.dv;
  assign in_tail = end_now || (tail_q != '0);
  assign word    = fcs_ok ? ~gen_crc : gen_crc;

  rxts_crc_nib u_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!head.body),
    .en   (head.body && !in_tail),
    .nib  (head.nib),
    .crc  (gen_crc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_dv     <= 1'b0;
      out_nib    <= '0;
      out_mod    <= 1'b0;
      fcs_active <= 1'b0;
      tail_q     <= '0;
      rep_q      <= 1'b0;
      shift_q    <= '0;
    end else begin
      out_dv <= head.dv;
      if (end_now) begin
        tail_q     <= CNT_W'(DEPTH - 1);
        rep_q      <= csp_hit;
        shift_q    <= word >> NIB_W;
        out_nib    <= csp_hit ? word[NIB_W-1:0] : head.nib;
        out_mod    <= csp_hit;
        fcs_active <= csp_hit;
      end else if (tail_q != '0) begin
        tail_q     <= tail_q - 1'b1;
        shift_q    <= shift_q >> NIB_W;
        out_nib    <= rep_q ? shift_q[NIB_W-1:0] : head.nib;
        out_mod    <= rep_q;
        fcs_active <= rep_q;
      end else begin
        out_nib    <= head.nib;
        out_mod    <= head.ins;
        fcs_active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxts_inserter.sv
module rxts_inserter
  import rxts_pkg::*;
#(
  parameter logic [15:0] CSP_TYPE     = 16'h88B5,
  parameter int          TS_W         = 64,
  parameter int          HDR_BYTES    = 14,
  parameter int          TS_SLOT_BYTE = 8,
  parameter int          IDX_W        = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] ts_in,
  input  logic            in_dv,
  input  logic [3:0]      in_nib,
  output logic            out_dv,
  output logic [3:0]      out_nib
);
  localparam int FCS_NIBS = CRC_W / NIB_W;

  stage_t st0;
  logic   csp_hit;
  logic   fcs_ok;
  logic   ins_en;
  logic   out_mod_w;
  logic   fcs_active_w;

  rxts_frame_parse #(
    .CSP_TYPE    (CSP_TYPE),
    .TS_W        (TS_W),
    .HDR_BYTES   (HDR_BYTES),
    .TS_SLOT_BYTE(TS_SLOT_BYTE),
    .IDX_W       (IDX_W)
  ) u_parse (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_dv  (in_dv),
    .in_nib (in_nib),
    .ts_in  (ts_in),
    .st_out (st0),
    .csp_hit(csp_hit),
    .fcs_ok (fcs_ok),
    .ins_en (ins_en)
  );

  rxts_fcs_out #(
    .DEPTH(FCS_NIBS)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_in     (st0),
    .csp_hit   (csp_hit),
    .fcs_ok    (fcs_ok),
    .out_dv    (out_dv),
    .out_nib   (out_nib),
    .out_mod   (out_mod_w),
    .fcs_active(fcs_active_w)
  );
endmodule

// File: rtl/rxts_inserter_chk.sv
module rxts_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_dv,
  input logic [3:0] in_nib,
  input logic       out_dv,
  input logic [3:0] out_nib,
  input logic       out_mod,
  input logic       fcs_active
);
  localparam int LAT = 9;
  logic [3:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cyc_q <= '0;
    else if (cyc_q != 4'hF)   cyc_q <= cyc_q + 1'b1;
  end

  // R1: fixed delay of the valid flag
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 4'(LAT)) |-> (out_dv == $past(in_dv, LAT)));

  // R1: quiet data bus between frames
  assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_dv |-> (out_nib == 4'h0));

  // R2: nibbles not marked as replaced equal the delayed input
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_q >= 4'(LAT)) && out_dv && !out_mod) |-> (out_nib == $past(in_nib, LAT)));

  // R6: replaced FCS nibbles only inside a valid frame
  assert_fcs_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_active |-> out_dv);

  // R4: modified nibbles only inside a valid frame
  assert_mod_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_mod |-> out_dv);
endmodule

bind rxts_inserter rxts_inserter_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_dv     (in_dv),
  .in_nib    (in_nib),
  .out_dv    (out_dv),
  .out_nib   (out_nib),
  .out_mod   (out_mod_w),
  .fcs_active(fcs_active_w)
);

// File: tb/rxts_inserter_tb_top.sv
module rxts_inserter_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] CSP_T      = 16'h88B5;
  localparam int          PRE_NIBS   = 15;

  typedef logic [7:0] bq_t[$];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ts_in = 64'h0123_4567_89AB_CDEF;
  logic        in_dv = 1'b0;
  logic [3:0]  in_nib = 4'h0;
  logic        out_dv;
  logic [3:0]  out_nib;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int out_first = -1;
  int in_first = -1;
  int idle_bad = 0;
  logic [3:0] cap_q[$];
  logic [3:0] exp_q[$];
  logic [63:0] last_ts;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxts_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .ts_in(ts_in),
    .in_dv(in_dv), .in_nib(in_nib), .out_dv(out_dv), .out_nib(out_nib)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_dv) begin
        cap_q.push_back(out_nib);
        if (out_first < 0) out_first = cyc;
      end else if (out_nib != 4'h0) begin
        idle_bad++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input bq_t b);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFFFFFF;
    foreach (b[i]) begin
      for (int j = 0; j < 8; j++) begin
        fb = c[0] ^ b[i][j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  function automatic bq_t mk_body(input logic [15:0] ty, input logic [7:0] seed);
    bq_t b;
    for (int i = 0; i < 6; i++) b.push_back(8'h02 + 8'(i));
    for (int i = 0; i < 6; i++) b.push_back(seed ^ 8'(i * 5));
    b.push_back(ty[15:8]);
    b.push_back(ty[7:0]);
    for (int i = 0; i < 50; i++) b.push_back(seed + 8'(i * 13));
    return b;
  endfunction

  task automatic drv(input logic dv, input logic [3:0] nib);
    @(negedge clk);
    in_dv  = dv;
    in_nib = nib;
    ts_in  = ts_in + 64'h0000_0101_0000_0003;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drv(1'b0, 4'h0);
  endtask

  task automatic send_one(input bq_t body, input bit bad, input int pre);
    bq_t fr;
    bq_t ex;
    logic [31:0] f;
    logic [31:0] f2;
    bit csp;
    f = fcs_of(body);
    if (bad) f = f ^ 32'h0000_0100;
    fr = body;
    for (int i = 0; i < 4; i++) fr.push_back(f[8*i +: 8]);
    for (int i = 0; i < pre; i++) begin
      drv(1'b1, 4'h5);
      if (in_first < 0) in_first = cyc;
    end
    drv(1'b1, 4'hD);
    last_ts = ts_in;
    foreach (fr[i]) begin
      drv(1'b1, fr[i][3:0]);
      drv(1'b1, fr[i][7:4]);
    end
    csp = ({body[12], body[13]} == CSP_T);
    ex = body;
    if (csp) begin
      for (int b = 0; b < 8; b++) ex[22+b] = last_ts[63-8*b -: 8];
      f2 = fcs_of(ex);
      if (bad) f2 = ~f2;
    end else begin
      f2 = f;
    end
    for (int i = 0; i < 4; i++) ex.push_back(f2[8*i +: 8]);
    for (int i = 0; i < pre; i++) exp_q.push_back(4'h5);
    exp_q.push_back(4'hD);
    foreach (ex[i]) begin
      exp_q.push_back(ex[i][3:0]);
      exp_q.push_back(ex[i][7:4]);
    end
  endtask

  task automatic start_capture();
    cap_q.delete();
    exp_q.delete();
    out_first = -1;
    in_first  = -1;
  endtask

  task automatic compare(input string req);
    int bad_at;
    idle(16);
    check(cap_q.size() == exp_q.size(), req, "nibble count",
          64'(cap_q.size()), 64'(exp_q.size()));
    bad_at = -1;
    if (cap_q.size() == exp_q.size())
      foreach (exp_q[i]) if (bad_at < 0 && cap_q[i] != exp_q[i]) bad_at = i;
    if (bad_at >= 0)
      check(1'b0, req, $sformatf("nibble %0d", bad_at), 64'(cap_q[bad_at]), 64'(exp_q[bad_at]));
    else
      check(1'b1, req, "content", 0, 0);
  endtask

  function automatic bq_t cap_bytes(input int pre);
    bq_t b;
    for (int i = pre + 1; i + 1 < cap_q.size(); i += 2) b.push_back({cap_q[i+1], cap_q[i]});
    return b;
  endfunction

  task automatic t_reset();
    check(out_dv == 1'b0, "R1", "out_dv after reset", 64'(out_dv), 0);
    check(out_nib == 4'h0, "R1", "out_nib after reset", 64'(out_nib), 0);
  endtask

  task automatic t_plain_good();
    start_capture();
    send_one(mk_body(16'h0800, 8'h31), 1'b0, PRE_NIBS);
    compare("R2");
  endtask

  task automatic t_plain_bad();
    start_capture();
    send_one(mk_body(16'h0806, 8'h47), 1'b1, PRE_NIBS);
    compare("R2");
  endtask

  task automatic t_csp_good();
    bq_t body;
    bq_t ob;
    bq_t pl;
    logic [31:0] rx_fcs;
    logic [63:0] got_ts;
    start_capture();
    body = mk_body(CSP_T, 8'h5A);
    send_one(body, 1'b0, PRE_NIBS);
    compare("R6");
    check(out_first - in_first == 9, "R1", "latency", 64'(out_first - in_first), 9);
    ob = cap_bytes(PRE_NIBS);
    if (ob.size() == 68) begin
      for (int b = 0; b < 8; b++) got_ts[63-8*b -: 8] = ob[22+b];
      check(got_ts == last_ts, "R5", "timestamp at delimiter", got_ts, last_ts);
      check(ob[14] == body[14] && ob[21] == body[21], "R4", "tx slot untouched",
            {ob[14], ob[21]}, {body[14], body[21]});
      for (int i = 0; i < 64; i++) pl.push_back(ob[i]);
      rx_fcs = {ob[67], ob[66], ob[65], ob[64]};
      check(rx_fcs == fcs_of(pl), "R6", "output fcs valid", 64'(rx_fcs), 64'(fcs_of(pl)));
    end else begin
      check(1'b0, "R4", "output byte count", 64'(ob.size()), 68);
    end
  endtask

  task automatic t_csp_bad();
    bq_t ob;
    bq_t pl;
    logic [31:0] rx_fcs;
    start_capture();
    send_one(mk_body(CSP_T, 8'hC3), 1'b1, PRE_NIBS);
    compare("R7");
    ob = cap_bytes(PRE_NIBS);
    if (ob.size() == 68) begin
      for (int i = 0; i < 64; i++) pl.push_back(ob[i]);
      rx_fcs = {ob[67], ob[66], ob[65], ob[64]};
      check(rx_fcs == ~fcs_of(pl), "R7", "inverted fcs", 64'(rx_fcs), 64'(~fcs_of(pl)));
    end else begin
      check(1'b0, "R7", "output byte count", 64'(ob.size()), 68);
    end
  endtask

  task automatic t_type_rules();
    start_capture();
    send_one(mk_body({CSP_T[7:0], CSP_T[15:8]}, 8'h19), 1'b0, PRE_NIBS);
    compare("R3");
    start_capture();
    send_one(mk_body(CSP_T, 8'h77), 1'b0, 5);
    compare("R3");
  endtask

  task automatic t_back2back();
    start_capture();
    send_one(mk_body(CSP_T, 8'h11), 1'b0, PRE_NIBS);
    idle(1);
    send_one(mk_body(CSP_T, 8'h99), 1'b1, PRE_NIBS);
    compare("R8");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(12);
    t_reset();
    t_plain_good();
    t_plain_bad();
    t_csp_good();
    t_csp_bad();
    t_type_rules();
    t_back2back();
    check(idle_bad == 0, "R1", "idle nibbles nonzero", 64'(idle_bad), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule